// File: doc/BRIEF.md
# Widening 16x16 Unsigned Multiply Execution Unit

This unit runs one instruction of a small processor: a two-byte widening multiply that takes a 16-bit half of any general register and multiplies it, unsigned, by the low half of a 32-bit destination register. The full 32-bit product replaces the destination. The processor has eight 32-bit general registers, and each register splits into an upper and a lower 16-bit half. The unit decodes the two instruction bytes when they are issued. It reads both registers through two combinational read ports, captures the operands, and holds the instruction for a fixed number of cycles. It then writes the product through a single write port and pulses `done` in the same cycle. The unit has no condition-flag port, so the flags stay as they were.

Execution time is a base count set by a parameter (4 by default, 20 in a slow configuration). An interlock adds up to three cycles when the multiply is issued shortly after a multiply-accumulate operation completes. A saturating counter tracks the cycles since the last `mac_done` pulse. At issue, the shortfall of that counter below three becomes extra stall cycles.

The controller has four states. `IDLE` accepts an instruction. `RUN` counts down the stall. `FINISH` writes the result and raises `done`. `BAD` reports a rejected encoding. The transitions are:
- `IDLE` to `RUN` on a legal issue.
- `IDLE` to `BAD` on an illegal issue.
- `RUN` to `RUN` while the countdown is above one.
- `RUN` to `FINISH` when the countdown reaches one.
- `FINISH` to `IDLE`.
- `BAD` to `IDLE`.

Top module: `umul16_exec`

## Requirements
- R1: An instruction is accepted when `issue_valid` and `issue_ready` are both high. It is legal when the first byte is 0x52 and second-byte bit 3 is 0. Second-byte bits 7:4 carry the source code and bits 2:0 carry the destination register number.
- R2: In the 4-bit source code, bit 3 = 1 selects the upper half [31:16] and bit 3 = 0 selects the lower half [15:0]. Bits 2:0 give the register number.
- R3: The value written to the destination is the unsigned product of the selected source half and the destination's bits [15:0], written as the full 32 bits.
- R4: Both operands are captured in the issue cycle. A source that is either half of the destination register therefore contributes its value from before the write.
- R5: Each legal instruction causes exactly one register write. That write happens in the final cycle, together with a one-cycle `done` pulse. `issue_ready` is high only while idle.
- R6: With N = BASE_CYCLES + extra, `done` is high in the (N-1)th cycle after the issue cycle. The default for BASE_CYCLES is 4, and 20 is also supported.
- R7: The gap counter holds 3 after reset, clears to 0 on a `mac_done` pulse, and otherwise rises by one per cycle, saturating at 3. At issue, extra = 3 - gap. An issue in the cycle right after the pulse therefore adds 3 cycles, and each intervening cycle removes one.
- R8: If the first byte is not 0x52 or second-byte bit 3 is 1, `illegal` pulses in the cycle after issue. No register write occurs, and the unit returns to idle.
- R9: After reset, `issue_ready` is 1 and `done`, `illegal` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction bytes present |
| issue_ready | output | 1 | Unit idle, able to accept |
| issue_byte0 | input | 8 | First instruction byte |
| issue_byte1 | input | 8 | Second instruction byte |
| rf_src_idx | output | 3 | Source register read index |
| rf_src_data | input | 32 | Source register read data |
| rf_dst_idx | output | 3 | Destination register read index |
| rf_dst_data | input | 32 | Destination register read data |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 3 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mac_done | input | 1 | Pulse: a multiply-accumulate just completed |
| done | output | 1 | Pulse: multiply complete, result written |
| illegal | output | 1 | Pulse: rejected encoding |

## Verification
The bench builds the unit with the default base of 4 cycles. This keeps each instruction short enough for a full sweep of all sixteen source halves against all eight destinations, aliasing pairs included, with fresh register contents for each pair. The short base also lets the interlock sweep place the issue at every distance from zero to five cycles after a multiply-accumulate pulse. That covers each stall value and the saturated case. The 20-cycle base changes only the loaded count, and the bench does not build it.

// File: rtl/umul16_pkg.sv
package umul16_pkg;
    localparam int          DATA_W     = 32;
    localparam int          HALF_W     = DATA_W / 2;
    localparam int          NREGS      = 8;
    localparam int          REG_AW     = $clog2(NREGS);
    localparam int          MAC_WINDOW = 3;
    localparam int          GAP_W      = $clog2(MAC_WINDOW + 1);
    localparam logic [7:0]  OPCODE     = 8'h52;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH,
        ST_BAD
    } ustate_t;
endpackage

// File: rtl/umul16_decode.sv
module umul16_decode
    import umul16_pkg::*;
(
    input  logic [7:0]        byte0,
    input  logic [7:0]        byte1,
    output logic              legal,
    output logic              src_upper,
    output logic [REG_AW-1:0] src_reg,
    output logic [REG_AW-1:0] dst_reg
);
    always_comb begin
        legal     = (byte0 == OPCODE) && !byte1[3];
        src_upper = byte1[7];
        src_reg   = byte1[6:4];
        dst_reg   = byte1[2:0];
    end
endmodule

// File: rtl/umul16_mac_gap.sv
module umul16_mac_gap
    import umul16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mac_pulse,
    output logic [GAP_W-1:0] extra
);
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap <= GAP_W'(MAC_WINDOW);
        else if (mac_pulse)
            gap <= '0;
        else if (gap != GAP_W'(MAC_WINDOW))
            gap <= gap + 1'b1;
    end

    always_comb extra = GAP_W'(MAC_WINDOW) - gap;

    // R7: a pulse clears the distance
    a_r7_gap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mac_pulse |=> (gap == '0));
    // R7: distance advances one per cycle until saturation
    a_r7_gap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_pulse && gap != GAP_W'(MAC_WINDOW)) |=> (gap == $past(gap) + 1'b1));
    // R7: never beyond the window
    a_r7_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GAP_W'(MAC_WINDOW));
endmodule

// File: rtl/umul16_ctrl.sv
module umul16_ctrl
    import umul16_pkg::*;
#(
    parameter int BASE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic             legal,
    input  logic [GAP_W-1:0] extra,
    output logic             issue_ready,
    output logic             accept,
    output logic             done,
    output logic             illegal
);
    localparam int CNT_W = $clog2(BASE_CYCLES + MAC_WINDOW);

    ustate_t          state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (legal) begin
                        state_nx = ST_RUN;
                        cnt_nx   = CNT_W'(BASE_CYCLES - 2) + CNT_W'(extra);
                    end else begin
                        state_nx = ST_BAD;
                    end
                end
            end
            ST_RUN: begin
                if (cnt == CNT_W'(1))
                    state_nx = ST_FINISH;
                else
                    cnt_nx = cnt - 1'b1;
            end
            ST_FINISH: state_nx = ST_IDLE;
            ST_BAD:    state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        issue_ready = (state == ST_IDLE);
        accept      = issue_ready && issue_valid;
        done        = (state == ST_FINISH);
        illegal     = (state == ST_BAD);
    end

    // R5: completion always returns the unit to idle
    a_r5_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> issue_ready);
    // R8: a rejection lasts one cycle and is never followed by completion
    a_r8_bad_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (issue_ready && !done));
    // R6: countdown never underflows while running
    a_r6_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt != '0));
endmodule

// File: rtl/umul16_exec.sv
module umul16_exec
    import umul16_pkg::*;
#(
    parameter int BASE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [7:0]        issue_byte0,
    input  logic [7:0]        issue_byte1,
    output logic [REG_AW-1:0] rf_src_idx,
    input  logic [DATA_W-1:0] rf_src_data,
    output logic [REG_AW-1:0] rf_dst_idx,
    input  logic [DATA_W-1:0] rf_dst_data,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_widx,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic              mac_done,
    output logic              done,
    output logic              illegal
);
    logic              legal, src_upper, accept;
    logic [REG_AW-1:0] src_reg, dst_reg;
    logic [GAP_W-1:0]  extra;
    logic [HALF_W-1:0] src_q, dst_lo_q, src_half;
    logic [REG_AW-1:0] dst_q;

    umul16_decode u_dec (
        .byte0     (issue_byte0),
        .byte1     (issue_byte1),
        .legal     (legal),
        .src_upper (src_upper),
        .src_reg   (src_reg),
        .dst_reg   (dst_reg)
    );

    umul16_mac_gap u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .mac_pulse (mac_done),
        .extra     (extra)
    );

    umul16_ctrl #(.BASE_CYCLES(BASE_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .legal       (legal),
        .extra       (extra),
        .issue_ready (issue_ready),
        .accept      (accept),
        .done        (done),
        .illegal     (illegal)
    );

    always_comb begin
        rf_src_idx = src_reg;
        rf_dst_idx = dst_reg;
        src_half   = src_upper ? rf_src_data[DATA_W-1:HALF_W] : rf_src_data[HALF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_lo_q <= '0;
            dst_q    <= '0;
        end else if (accept && legal) begin
            src_q    <= src_half;
            dst_lo_q <= rf_dst_data[HALF_W-1:0];
            dst_q    <= dst_reg;
        end
    end

    always_comb begin
        rf_we    = done;
        rf_widx  = dst_q;
        rf_wdata = DATA_W'(src_q) * DATA_W'(dst_lo_q);
    end

    // R4: captured operands hold for the whole execution
    a_r4_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_ready && !done && !illegal) |=> ($stable(src_q) && $stable(dst_lo_q) && $stable(dst_q)));
    // R5: an accepted instruction makes the unit busy
    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !issue_ready);
    // R8: a rejected encoding never writes
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rf_we);
endmodule

// File: tb/umul16_exec_test.sv
module umul16_exec_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [7:0]  issue_byte0 = '0;
    logic [7:0]  issue_byte1 = '0;
    logic        mac_done = 1'b0;
    logic        issue_ready, rf_we, done, illegal;
    logic [2:0]  rf_src_idx, rf_dst_idx, rf_widx;
    logic [31:0] rf_src_data, rf_dst_data, rf_wdata;
    logic [31:0] regs [8];
    int          checks = 0;
    int          failures = 0;
    int          wr_cnt = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_src_data = regs[rf_src_idx];
    assign rf_dst_data = regs[rf_dst_idx];

    always @(posedge clk) if (rf_we) wr_cnt++;

    umul16_exec #(.BASE_CYCLES(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_byte0(issue_byte0), .issue_byte1(issue_byte1),
        .rf_src_idx(rf_src_idx), .rf_src_data(rf_src_data),
        .rf_dst_idx(rf_dst_idx), .rf_dst_data(rf_dst_data),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mac_done(mac_done), .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int i, input int s);
        case (s % 4)
            0:       return 32'hFFFF_FFFF;
            1:       return (i == 0) ? 32'h0 : 32'h0001_8000 + 32'(i);
            default: return 32'(s) * 32'h9E37_79B1 ^ 32'(i) * 32'h7F4A_7C15;
        endcase
    endfunction

    // Runs one instruction; starts and ends at a falling edge with the unit idle.
    task automatic run_op(input logic [7:0] b0, input logic [7:0] b1, input int mac_gap,
                          output int lat, output bit saw_done, output bit saw_bad,
                          output logic we, output logic [2:0] widx, output logic [31:0] wdata,
                          output int writes);
        int w0;
        if (mac_gap >= 0) begin
            mac_done = 1'b1;
            @(negedge clk);
            mac_done = 1'b0;
            repeat (mac_gap) @(negedge clk);
        end
        check(issue_ready === 1'b1, "R5 ready when idle", 32'(issue_ready), 32'h1);
        w0 = wr_cnt;
        issue_byte0 = b0;
        issue_byte1 = b1;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        issue_byte0 = 8'h00;
        issue_byte1 = 8'h00;
        lat = 1;
        while (!done && !illegal && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        saw_done = done;
        saw_bad  = illegal;
        we       = rf_we;
        widx     = rf_widx;
        wdata    = rf_wdata;
        @(negedge clk);
        writes = wr_cnt - w0;
        if (saw_done && we) regs[widx] = wdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat, writes;
        bit sd, sb;
        logic we;
        logic [2:0] widx;
        logic [31:0] wdata, exp;
        logic [15:0] sh;
        for (int i = 0; i < 8; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(issue_ready === 1'b1, "R9 ready", 32'(issue_ready), 32'h1);
        check(done === 1'b0, "R9 done", 32'(done), 32'h0);
        check(illegal === 1'b0, "R9 illegal", 32'(illegal), 32'h0);
        check(rf_we === 1'b0, "R9 rf_we", 32'(rf_we), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R6: all source halves against all destinations
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 8; d++) begin
                for (int i = 0; i < 8; i++) regs[i] = pattern(i, c * 8 + d);
                sh  = c[3] ? regs[c[2:0]][31:16] : regs[c[2:0]][15:0];
                exp = 32'(sh) * 32'(regs[d][15:0]);
                run_op(8'h52, {c[3:0], 1'b0, d[2:0]}, -1, lat, sd, sb, we, widx, wdata, writes);
                check(sd && we, "R1 legal completes", {30'h0, sd, we}, 32'h3);
                check(widx == d[2:0], "R1 dest index", 32'(widx), 32'(d));
                if (c[2:0] == d[2:0])
                    check(wdata === exp, "R4 aliased product", wdata, exp);
                else
                    check(wdata === exp, "R2 R3 product", wdata, exp);
                check(lat == 3, "R6 base latency", 32'(lat), 32'd3);
                check(writes == 1, "R5 one write", 32'(writes), 32'd1);
            end
        end

        // R7 R6: interlock at each distance from a multiply-accumulate pulse
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) regs[i] = pattern(i, 2 + k);
            exp = 32'(regs[1][31:16]) * 32'(regs[2][15:0]);
            run_op(8'h52, 8'h92, k, lat, sd, sb, we, widx, wdata, writes);
            check(lat == 3 + ((k < 3) ? 3 - k : 0), "R7 stall by distance", 32'(lat),
                  32'(3 + ((k < 3) ? 3 - k : 0)));
            check(wdata === exp, "R3 product after stall", wdata, exp);
        end

        // R8: rejected encodings
        for (int v = 0; v < 6; v++) begin
            logic [7:0] b0, b1;
            b0 = (v < 3) ? 8'h52 : 8'(8'h50 + v);
            b1 = (v < 3) ? 8'(8'h08 | (v * 8'h31)) : 8'h12;
            for (int i = 0; i < 8; i++) regs[i] = pattern(i, 7);
            run_op(b0, b1, -1, lat, sd, sb, we, widx, wdata, writes);
            check(sb && !sd, "R8 illegal flagged", {30'h0, sb, sd}, 32'h2);
            check(lat == 1, "R8 illegal timing", 32'(lat), 32'd1);
            check(writes == 0, "R8 no write", 32'(writes), 32'd0);
            check(issue_ready === 1'b1, "R8 back to idle", 32'(issue_ready), 32'h1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule